// File: doc/BRIEF.md
# Doorbell Message Send and Clear Unit

This unit turns a doorbell message word into per-core pending interrupt state for a small cluster of cores. When a send strobe is given, the word is decoded into an interrupt class and a set of target cores. Each target then gets its pending bit set and a one-cycle interrupt-request pulse. When a clear strobe is given, only the issuing core loses the pending bit that the word decodes to.

A mode input picks one of two message dialects. In embedded mode, a normal doorbell and a critical doorbell are honoured. Targets are picked by comparing each core's processor ID with a 14-bit tag, unless the broadcast bit is set. In server mode, only one message type is honoured. It raises a hypervisor doorbell, and targets are picked through a separate 12-bit tag with no broadcast. Guest-type messages and unknown types are dropped in both modes. Moving the message over a bus is left to the surrounding logic.

Top module: `doorbell_msg_unit`

## Requirements
- R1: After reset all pending vectors and all interrupt-request outputs are zero.
- R2: An embedded-mode send with type field msg[31:27] = 0 sets `db_pend_o` on every target core; the new state is visible after the clock edge that samples `send_i`.
- R3: An embedded-mode send with type 1 sets `crit_pend_o` on every target core.
- R4: Types 2, 3 and 4 (guest doorbell, guest critical, guest machine check) and types 6 to 31 change no pending bit and raise no interrupt request in either mode.
- R5: In embedded mode with msg[26] = 0, the targets are exactly the cores whose processor ID equals msg[13:0]. No match means no change.
- R6: In embedded mode, msg[26] = 1 targets every core, whatever the tag.
- R7: Each target of an honoured send sees `irq_o` high for exactly the one cycle following the sampling edge. Otherwise `irq_o` is low.
- R8: A clear with an honoured type removes only that class's pending bit, and only on the core given by `src_core_i`. All other bits are unchanged.
- R9: In server mode, only type 5 is honoured, and it sets `hyp_pend_o`. Types 0 and 1 have no effect.
- R10: In server mode, the targets are the cores whose processor ID equals the zero-extended msg[25:14]. The bit msg[26] is ignored.
- R11: If a send and a clear hit the same pending bit of the same core in one cycle, the bit ends up set.
- R12: A clear with an ignored type changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_i | input | 32 | Doorbell message word |
| send_i | input | 1 | Send strobe |
| clr_i | input | 1 | Clear strobe |
| src_core_i | input | 2 | Index of the core issuing a clear |
| srv_mode_i | input | 1 | 1 = server dialect, 0 = embedded dialect |
| core_pid_i | input | 56 | Processor ID of each core, 14 bits per core, core 0 in the low bits |
| db_pend_o | output | 4 | Pending normal doorbell per core |
| crit_pend_o | output | 4 | Pending critical doorbell per core |
| hyp_pend_o | output | 4 | Pending hypervisor doorbell per core |
| irq_o | output | 4 | Interrupt-request pulse per core |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. Both the pending vectors and the `irq_o` pulse come from one register stage. The bench changes inputs on the falling edge and lets one rising edge pass. It then compares all four output vectors on the next falling edge against its own model, so the pulse is seen in its single valid cycle. Reset release passes through a two-flop synchronizer, so the bench waits several cycles after releasing `rst_n` before it drives any strobe.

// File: rtl/dbmsg_pkg.sv
package dbmsg_pkg;
  localparam int MSG_W       = 32;
  localparam int TYPE_LSB    = 27;
  localparam int TYPE_W      = 5;
  localparam int BCAST_BIT   = 26;
  localparam int EMB_TAG_LSB = 0;
  localparam int EMB_TAG_W   = 14;
  localparam int SRV_TAG_LSB = 14;
  localparam int SRV_TAG_W   = 12;

  localparam logic [TYPE_W-1:0] T_DOORBELL = 5'd0;
  localparam logic [TYPE_W-1:0] T_CRITICAL = 5'd1;
  localparam logic [TYPE_W-1:0] T_SERVER   = 5'd5;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_DB   = 2'd1,
    CLS_CRIT = 2'd2,
    CLS_HYP  = 2'd3
  } db_cls_e;
endpackage

// File: rtl/dbmsg_decode.sv
module dbmsg_decode
  import dbmsg_pkg::*;
#(
  parameter int PID_W = 14
) (
  input  logic [MSG_W-1:0] msg_i,
  input  logic             srv_mode_i,
  output db_cls_e          cls_o,
  output logic             bcast_o,
  output logic [PID_W-1:0] tag_o
);
  logic [TYPE_W-1:0] msg_type;

  assign msg_type = msg_i[TYPE_LSB +: TYPE_W];

  always_comb begin
    cls_o = CLS_NONE;
    if (srv_mode_i) begin
      if (msg_type == T_SERVER) cls_o = CLS_HYP;
    end else begin
      case (msg_type)
        T_DOORBELL: cls_o = CLS_DB;
        T_CRITICAL: cls_o = CLS_CRIT;
        default:    cls_o = CLS_NONE;
      endcase
    end
  end

  always_comb begin
    if (srv_mode_i) begin
      bcast_o = 1'b0;
      tag_o   = PID_W'(msg_i[SRV_TAG_LSB +: SRV_TAG_W]);
    end else begin
      bcast_o = msg_i[BCAST_BIT];
      tag_o   = PID_W'(msg_i[EMB_TAG_LSB +: EMB_TAG_W]);
    end
  end
endmodule

// File: rtl/dbmsg_target.sv
module dbmsg_target #(
  parameter int NUM_CORES = 4,
  parameter int PID_W     = 14
) (
  input  logic [NUM_CORES*PID_W-1:0] core_pid_i,
  input  logic [PID_W-1:0]           tag_i,
  input  logic                       bcast_i,
  output logic [NUM_CORES-1:0]       hit_o
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_match
    assign hit_o[g] = bcast_i || (core_pid_i[g*PID_W +: PID_W] == tag_i);
  end
endmodule

// File: rtl/dbmsg_pend_bank.sv
module dbmsg_pend_bank #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] set_db_i,
  input  logic [NUM_CORES-1:0] set_crit_i,
  input  logic [NUM_CORES-1:0] set_hyp_i,
  input  logic [NUM_CORES-1:0] clr_db_i,
  input  logic [NUM_CORES-1:0] clr_crit_i,
  input  logic [NUM_CORES-1:0] clr_hyp_i,
  output logic [NUM_CORES-1:0] db_q,
  output logic [NUM_CORES-1:0] crit_q,
  output logic [NUM_CORES-1:0] hyp_q,
  output logic [NUM_CORES-1:0] irq_q
);
  logic [NUM_CORES-1:0] db_d, crit_d, hyp_d, irq_d;
  logic                 pend_en;

  always_comb begin
    db_d    = (db_q   & ~clr_db_i)   | set_db_i;
    crit_d  = (crit_q & ~clr_crit_i) | set_crit_i;
    hyp_d   = (hyp_q  & ~clr_hyp_i)  | set_hyp_i;
    irq_d   = set_db_i | set_crit_i | set_hyp_i;
    pend_en = |{set_db_i, set_crit_i, set_hyp_i, clr_db_i, clr_crit_i, clr_hyp_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q   <= '0;
      crit_q <= '0;
      hyp_q  <= '0;
    end else if (pend_en) begin
      db_q   <= db_d;
      crit_q <= crit_d;
      hyp_q  <= hyp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_db_i[g] || set_crit_i[g] || set_hyp_i[g]) |=>
        ((db_q[g] || !$past(set_db_i[g])) && (crit_q[g] || !$past(set_crit_i[g]))
         && (hyp_q[g] || !$past(set_hyp_i[g]))));
    assert_irq_has_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> (db_q[g] || crit_q[g] || hyp_q[g]));
  end
endmodule

// File: rtl/doorbell_msg_unit.sv
module doorbell_msg_unit
  import dbmsg_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int PID_W      = 14,
  localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MSG_W-1:0]           msg_i,
  input  logic                       send_i,
  input  logic                       clr_i,
  input  logic [CORE_IDX_W-1:0]      src_core_i,
  input  logic                       srv_mode_i,
  input  logic [NUM_CORES*PID_W-1:0] core_pid_i,
  output logic [NUM_CORES-1:0]       db_pend_o,
  output logic [NUM_CORES-1:0]       crit_pend_o,
  output logic [NUM_CORES-1:0]       hyp_pend_o,
  output logic [NUM_CORES-1:0]       irq_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  db_cls_e              cls;
  logic                 bcast;
  logic [PID_W-1:0]     tag;
  logic [NUM_CORES-1:0] hit;
  logic [NUM_CORES-1:0] send_mask, clr_mask;
  logic [NUM_CORES-1:0] set_db, set_crit, set_hyp, clr_db, clr_crit, clr_hyp;

  dbmsg_decode #(.PID_W(PID_W)) u_decode (
    .msg_i      (msg_i),
    .srv_mode_i (srv_mode_i),
    .cls_o      (cls),
    .bcast_o    (bcast),
    .tag_o      (tag)
  );

  dbmsg_target #(.NUM_CORES(NUM_CORES), .PID_W(PID_W)) u_target (
    .core_pid_i (core_pid_i),
    .tag_i      (tag),
    .bcast_i    (bcast),
    .hit_o      (hit)
  );

  always_comb begin
    send_mask = send_i ? hit : '0;
    clr_mask  = clr_i ? (NUM_CORES'(1) << src_core_i) : '0;
    set_db    = (cls == CLS_DB)   ? send_mask : '0;
    set_crit  = (cls == CLS_CRIT) ? send_mask : '0;
    set_hyp   = (cls == CLS_HYP)  ? send_mask : '0;
    clr_db    = (cls == CLS_DB)   ? clr_mask  : '0;
    clr_crit  = (cls == CLS_CRIT) ? clr_mask  : '0;
    clr_hyp   = (cls == CLS_HYP)  ? clr_mask  : '0;
  end

  dbmsg_pend_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_db_i   (set_db),
    .set_crit_i (set_crit),
    .set_hyp_i  (set_hyp),
    .clr_db_i   (clr_db),
    .clr_crit_i (clr_crit),
    .clr_hyp_i  (clr_hyp),
    .db_q       (db_pend_o),
    .crit_q     (crit_pend_o),
    .hyp_q      (hyp_pend_o),
    .irq_q      (irq_o)
  );

  assert_ignored_type_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cls == CLS_NONE) |=> (irq_o == '0));

  assert_server_leaves_embedded_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (srv_mode_i && !(clr_i && !srv_mode_i)) |=> ($stable(db_pend_o) && $stable(crit_pend_o)));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_clr_chk
    assert_clear_issuer_only_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (clr_i && !send_i && (src_core_i != CORE_IDX_W'(g))) |=>
        ($stable(db_pend_o[g]) && $stable(crit_pend_o[g]) && $stable(hyp_pend_o[g])));
  end
endmodule

// File: tb/doorbell_msg_unit_bench.sv
`timescale 1ns/1ps
module doorbell_msg_unit_bench;
  localparam int NC = 4;
  localparam int PW = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     msg = '0;
  logic            send = 1'b0, clr = 1'b0, srv = 1'b0;
  logic [1:0]      src = '0;
  logic [NC*PW-1:0] pid = '0;
  logic [NC-1:0]   db_o, crit_o, hyp_o, irq_o;

  logic [NC-1:0]   e_db = '0, e_crit = '0, e_hyp = '0, e_irq = '0;
  int              n_chk = 0, n_bad = 0;
  int              cyc = 0;

  always #10 clk = ~clk;

  doorbell_msg_unit u_doorbell_msg_unit (
    .clk(clk), .rst_n(rst_n), .msg_i(msg), .send_i(send), .clr_i(clr),
    .src_core_i(src), .srv_mode_i(srv), .core_pid_i(pid),
    .db_pend_o(db_o), .crit_pend_o(crit_o), .hyp_pend_o(hyp_o), .irq_o(irq_o)
  );

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=hung exp=done");
      summary_and_end();
    end
  end

  function automatic logic [31:0] mk(input int ty, input bit bc, input int stag, input int etag);
    return {5'(ty), bc, 12'(stag), 14'(etag)};
  endfunction

  // class: 0 none, 1 db, 2 crit, 3 hyp
  function automatic int cls_of(input logic [31:0] m, input bit s);
    if (s) return (m[31:27] == 5'd5) ? 3 : 0;
    if (m[31:27] == 5'd0) return 1;
    if (m[31:27] == 5'd1) return 2;
    return 0;
  endfunction

  function automatic logic [NC-1:0] tgt_of(input logic [31:0] m, input bit s, input logic [NC*PW-1:0] p);
    logic [NC-1:0] t;
    for (int i = 0; i < NC; i++) begin
      if (s) t[i] = (p[i*PW +: PW] == {2'b00, m[25:14]});
      else   t[i] = m[26] || (p[i*PW +: PW] == m[13:0]);
    end
    return t;
  endfunction

  task automatic chk(input string req, input string what, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] m, input bit s_, input bit c_, input int sc, input bit sv, input string req);
    int            c;
    logic [NC-1:0] sm, cm;
    msg = m; send = s_; clr = c_; src = 2'(sc); srv = sv;
    c  = cls_of(m, sv);
    sm = (s_ && c != 0) ? tgt_of(m, sv, pid) : '0;
    cm = (c_ && c != 0) ? (NC'(1) << sc) : '0;
    if (c == 1) e_db   = (e_db   & ~cm) | sm;
    if (c == 2) e_crit = (e_crit & ~cm) | sm;
    if (c == 3) e_hyp  = (e_hyp  & ~cm) | sm;
    e_irq = sm;
    @(posedge clk);
    @(negedge clk);
    send = 1'b0; clr = 1'b0;
    chk(req, "db",   db_o,   e_db);
    chk(req, "crit", crit_o, e_crit);
    chk(req, "hyp",  hyp_o,  e_hyp);
    chk(req, "irq",  irq_o,  e_irq);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "db", db_o, '0); chk("R1", "crit", crit_o, '0);
    chk("R1", "hyp", hyp_o, '0); chk("R1", "irq", irq_o, '0);

    pid = {14'd100, 14'd5, 14'd9, 14'd5};              // cores 3..0
    step(mk(0, 0, 0, 5),   1, 0, 0, 0, "R2_R5_R7");    // cores 0,2 db
    step(mk(1, 0, 0, 9),   1, 0, 0, 0, "R3");          // core 1 crit
    step(mk(2, 1, 0, 5),   1, 0, 0, 0, "R4");
    step(mk(3, 1, 0, 5),   1, 0, 0, 0, "R4");
    step(mk(4, 1, 0, 9),   1, 0, 0, 0, "R4");
    step(mk(7, 1, 0, 5),   1, 0, 0, 0, "R4");
    step(mk(0, 0, 0, 3),   1, 0, 0, 0, "R5");          // no match
    step(mk(0, 1, 0, 777), 1, 0, 0, 0, "R6");          // all cores db
    step(mk(0, 0, 0, 0),   0, 1, 2, 0, "R8");          // clear db on core 2
    step(mk(1, 0, 0, 0),   0, 1, 0, 0, "R8");          // clear crit core 0 (none)
    step(mk(3, 0, 0, 0),   0, 1, 1, 0, "R12");         // ignored type
    step(mk(5, 0, 100, 0), 1, 0, 0, 1, "R9_R10");      // core 3 hyp
    step(mk(5, 1, 7, 5),   1, 0, 0, 1, "R10");         // no broadcast
    step(mk(0, 1, 5, 5),   1, 0, 0, 1, "R9");          // embedded type in server
    step(mk(0, 0, 0, 5),   1, 1, 0, 0, "R11");         // set wins on core 0
    step(mk(5, 0, 100, 0), 1, 1, 3, 1, "R11");

    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 0)
        for (int i = 0; i < NC; i++) pid[i*PW +: PW] = 14'($urandom_range(0, 3));
      step(mk($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
           1'($urandom_range(0, 1)), "R2_R3_R7_R8_R9_R11");
    end
    summary_and_end();
  end
endmodule